// File: doc/BRIEF.md
# Tagged-Byte Parallel Command Receiver

This block takes drawing commands from a host that writes bytes to a slow 8-bit parallel port with no strobe line. A line-rate tick (one pulse per horizontal sync) decides when the port is looked at. The host holds each byte for many tick periods. A new byte is recognised only because the sampled value differs from the one sampled before. Every byte carries a 3-bit tag in its top bits, and each field has its own tag, so two bytes in a row are never equal even when their data bits match.

The receiver steers each byte's 5 data bits into the opcode, X or Y field named by its tag. It rebuilds the two 10-bit coordinates from their low and high halves. When a sequence is complete, it presents the whole command with a single-cycle valid pulse. Whatever consumes the command, such as a pixel or line engine, sits outside this block.

Top module: `tagcmd_rx`

## Requirements
- R1: While reset is applied and after it is released, `cmd_valid_o` is 0 and `cmd_op_o`, `cmd_x_o` and `cmd_y_o` are all zero until the first command is emitted.
- R2: The port passes through a two-flop synchronizer and is sampled only on clock cycles where `line_tick_i` is 1. Port changes with no tick produce no command.
- R3: A byte is taken only when the sampled value differs from the previous sample. Ticking repeatedly over an unchanged port value takes that byte once.
- R4: Bits [7:5] of a byte are its tag and bits [4:0] its data. Tag 000 is the opcode, 001 is X low, 010 is X high, 011 is Y low and 100 is Y high.
- R5: `cmd_x_o` = {X high data, X low data} and `cmd_y_o` = {Y high data, Y low data}, each 10 bits wide.
- R6: A Y-high byte emits a command only if an opcode byte has been taken since the last emission, followed by X low, X high and Y low bytes in any order. `cmd_valid_o` is then 1 for exactly one cycle, two clock cycles after the tick cycle that sampled the Y-high byte.
- R7: An opcode byte restarts assembly. The X low, X high and Y low bytes taken before it no longer count toward completion.
- R8: Bytes with tags 101, 110 or 111 are ignored. They change no field and produce no command.
- R9: `cmd_op_o`, `cmd_x_o` and `cmd_y_o` change only in the cycle where `cmd_valid_o` is 1, and hold their values otherwise.
- R10: After a command is emitted, a further Y-high byte emits nothing until a new opcode, X low, X high and Y low set has been taken.
- R11: `cmd_op_o` carries the 5 data bits of the opcode byte unchanged. Values 1, 2 and 3 name set-pixel, move-cursor and draw-line.
- R12: After reset the previous-sample reference is 0x00, so a port held at 0x00 is not taken as a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| port_i | input | 8 | Host parallel port, asynchronous to `clk` |
| line_tick_i | input | 1 | One-cycle sample strobe, one per horizontal line |
| cmd_valid_o | output | 1 | One-cycle pulse when a complete command is presented |
| cmd_op_o | output | 5 | Opcode of the last command |
| cmd_x_o | output | 10 | X coordinate of the last command |
| cmd_y_o | output | 10 | Y coordinate of the last command |

## Verification
The bench holds the port across several ticks to catch a receiver that takes one byte more than once or that reacts to port changes between ticks. A wrong receiver would emit repeated or early commands. Opcode bytes sent in the middle of a sequence, Y-high bytes sent after an emission, and a 0x00 byte right after reset would all yield spurious commands in a design that keeps stale progress or starts with the wrong reference value. Reserved-tag bytes are mixed into random sequences with shuffled field order, so any leak of reserved data into a field shows up as a wrong coordinate. The exact pulse cycle and the all-ones and all-zeros coordinate halves are checked directly.

// File: rtl/tagcmd_pkg.sv
package tagcmd_pkg;
  localparam int TAG_W   = 3;
  localparam int PAY_W   = 5;
  localparam int BYTE_W  = TAG_W + PAY_W;
  localparam int COORD_W = 2 * PAY_W;

  localparam logic [TAG_W-1:0] TAG_OP = 3'd0;
  localparam logic [TAG_W-1:0] TAG_XL = 3'd1;
  localparam logic [TAG_W-1:0] TAG_XH = 3'd2;
  localparam logic [TAG_W-1:0] TAG_YL = 3'd3;
  localparam logic [TAG_W-1:0] TAG_YH = 3'd4;

  typedef struct packed {
    logic [PAY_W-1:0]   op;
    logic [COORD_W-1:0] x;
    logic [COORD_W-1:0] y;
  } cmd_t;
endpackage

// File: rtl/tagcmd_sync.sv
module tagcmd_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[0] <= '0;
        else        stg_q[0] <= d_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= '0;
        else        stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/tagcmd_edge.sv
module tagcmd_edge
  import tagcmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [BYTE_W-1:0] smp_i,
  output logic              stb_o,
  output logic [BYTE_W-1:0] byte_o
);
  logic [BYTE_W-1:0] prev_q, prev_d;
  logic [BYTE_W-1:0] byte_q, byte_d;
  logic              stb_q, stb_d;

  always_comb begin
    prev_d = prev_q;
    byte_d = byte_q;
    stb_d  = 1'b0;
    if (tick_i) begin
      prev_d = smp_i;
      if (smp_i != prev_q) begin
        stb_d  = 1'b1;
        byte_d = smp_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      byte_q <= '0;
      stb_q  <= 1'b0;
    end else begin
      stb_q <= stb_d;
      if (tick_i) begin
        prev_q <= prev_d;
        byte_q <= byte_d;
      end
    end
  end

  assign stb_o  = stb_q;
  assign byte_o = byte_q;
endmodule

// File: rtl/tagcmd_asm.sv
module tagcmd_asm
  import tagcmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              valid_o,
  output cmd_t              cmd_o
);
  logic [TAG_W-1:0] tag;
  logic [PAY_W-1:0] pay;

  logic [PAY_W-1:0] op_q, op_d, xl_q, xl_d, xh_q, xh_d, yl_q, yl_d;
  logic             h_op_q, h_op_d, h_xl_q, h_xl_d, h_xh_q, h_xh_d, h_yl_q, h_yl_d;
  logic             valid_q, valid_d;
  cmd_t             out_q, out_d;

  assign tag = byte_i[BYTE_W-1 -: TAG_W];
  assign pay = byte_i[PAY_W-1:0];

  always_comb begin
    op_d = op_q; xl_d = xl_q; xh_d = xh_q; yl_d = yl_q;
    h_op_d = h_op_q; h_xl_d = h_xl_q; h_xh_d = h_xh_q; h_yl_d = h_yl_q;
    out_d   = out_q;
    valid_d = 1'b0;
    if (stb_i) begin
      unique case (tag)
        TAG_OP: begin
          op_d = pay; h_op_d = 1'b1;
          h_xl_d = 1'b0; h_xh_d = 1'b0; h_yl_d = 1'b0;
        end
        TAG_XL: begin xl_d = pay; h_xl_d = 1'b1; end
        TAG_XH: begin xh_d = pay; h_xh_d = 1'b1; end
        TAG_YL: begin yl_d = pay; h_yl_d = 1'b1; end
        TAG_YH: begin
          if (h_op_q && h_xl_q && h_xh_q && h_yl_q) begin
            valid_d  = 1'b1;
            out_d.op = op_q;
            out_d.x  = {xh_q, xl_q};
            out_d.y  = {pay, yl_q};
            h_op_d = 1'b0; h_xl_d = 1'b0; h_xh_d = 1'b0; h_yl_d = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= '0; xl_q <= '0; xh_q <= '0; yl_q <= '0;
      h_op_q <= 1'b0; h_xl_q <= 1'b0; h_xh_q <= 1'b0; h_yl_q <= 1'b0;
      valid_q <= 1'b0;
      out_q   <= '0;
    end else begin
      valid_q <= valid_d;
      if (stb_i) begin
        op_q <= op_d; xl_q <= xl_d; xh_q <= xh_d; yl_q <= yl_d;
        h_op_q <= h_op_d; h_xl_q <= h_xl_d; h_xh_q <= h_xh_d; h_yl_q <= h_yl_d;
      end
      if (valid_d) out_q <= out_d;
    end
  end

  assign valid_o = valid_q;
  assign cmd_o   = out_q;
endmodule

// File: rtl/tagcmd_rx.sv
module tagcmd_rx
  import tagcmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [BYTE_W-1:0]  port_i,
  input  logic               line_tick_i,
  output logic               cmd_valid_o,
  output logic [PAY_W-1:0]   cmd_op_o,
  output logic [COORD_W-1:0] cmd_x_o,
  output logic [COORD_W-1:0] cmd_y_o
);
  logic [1:0]        rst_pipe_q;
  logic              rst_int_n;
  logic [BYTE_W-1:0] port_s;
  logic              byte_stb;
  logic [BYTE_W-1:0] byte_val;
  cmd_t              cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  tagcmd_sync #(.W(BYTE_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .d_i(port_i), .q_o(port_s)
  );

  tagcmd_edge u_edge (
    .clk(clk), .rst_n(rst_int_n), .tick_i(line_tick_i), .smp_i(port_s),
    .stb_o(byte_stb), .byte_o(byte_val)
  );

  tagcmd_asm u_asm (
    .clk(clk), .rst_n(rst_int_n), .stb_i(byte_stb), .byte_i(byte_val),
    .valid_o(cmd_valid_o), .cmd_o(cmd)
  );

  assign cmd_op_o = cmd.op;
  assign cmd_x_o  = cmd.x;
  assign cmd_y_o  = cmd.y;
endmodule

// File: rtl/tagcmd_rx_chk.sv
module tagcmd_rx_chk
  import tagcmd_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               line_tick_i,
  input logic               byte_stb,
  input logic [BYTE_W-1:0]  byte_val,
  input logic               cmd_valid_o,
  input logic [PAY_W-1:0]   cmd_op_o,
  input logic [COORD_W-1:0] cmd_x_o,
  input logic [COORD_W-1:0] cmd_y_o
);
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |=> !cmd_valid_o);  // R6

  AST_VALID_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> $past(line_tick_i, 2));  // R2

  AST_VALID_ON_YHIGH: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> ($past(byte_stb) && $past(byte_val[BYTE_W-1 -: TAG_W]) == TAG_YH));  // R6

  AST_YHIGH_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> cmd_y_o[COORD_W-1 -: PAY_W] == $past(byte_val[PAY_W-1:0]));  // R5

  AST_RESERVED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_stb && byte_val[BYTE_W-1 -: TAG_W] > TAG_YH) |=> !cmd_valid_o);  // R8

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid_o |-> ($stable(cmd_op_o) && $stable(cmd_x_o) && $stable(cmd_y_o)));  // R9
endmodule

bind tagcmd_rx tagcmd_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .line_tick_i(line_tick_i),
  .byte_stb(byte_stb), .byte_val(byte_val),
  .cmd_valid_o(cmd_valid_o), .cmd_op_o(cmd_op_o),
  .cmd_x_o(cmd_x_o), .cmd_y_o(cmd_y_o)
);

// File: tb/tagcmd_rx_bench.sv
module tagcmd_rx_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] port_i;
  logic       line_tick_i;
  logic       cmd_valid_o;
  logic [4:0] cmd_op_o;
  logic [9:0] cmd_x_o, cmd_y_o;

  int checks = 0, errors = 0, pulses = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tagcmd_rx u_tagcmd_rx (
    .clk(clk), .rst_n(rst_n), .port_i(port_i), .line_tick_i(line_tick_i),
    .cmd_valid_o(cmd_valid_o), .cmd_op_o(cmd_op_o),
    .cmd_x_o(cmd_x_o), .cmd_y_o(cmd_y_o)
  );

  always @(negedge clk) if (cmd_valid_o) pulses++;

  function automatic logic [7:0] mk(input logic [2:0] tag, input logic [4:0] d);
    return {tag, d};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick_once();
    @(negedge clk) line_tick_i = 1'b1;
    @(negedge clk) line_tick_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk) port_i = b;
    repeat (3) @(negedge clk);
    tick_once();
  endtask

  task automatic send_cmd(input logic [4:0] op, input logic [9:0] x, input logic [9:0] y,
                          input int order, input bit rsv);
    send(mk(3'd0, op));
    for (int k = 0; k < 3; k++) begin
      int f;
      f = (order + k) % 3;
      if (f == 0) send(mk(3'd1, x[4:0]));
      else if (f == 1) send(mk(3'd2, x[9:5]));
      else send(mk(3'd3, y[4:0]));
      if (rsv) send(mk(3'(5 + k), 5'($urandom)));
    end
    send(mk(3'd4, y[9:5]));
  endtask

  task automatic expect_cmd(input string req, input int p0, input logic [4:0] op,
                            input logic [9:0] x, input logic [9:0] y);
    chk(pulses == p0 + 1, {req, " pulse"}, pulses - p0, 1);
    chk(cmd_op_o == op, {req, " op"}, cmd_op_o, op);
    chk(cmd_x_o == x, {req, " x"}, cmd_x_o, x);
    chk(cmd_y_o == y, {req, " y"}, cmd_y_o, y);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int p0;
    void'($urandom(32'd4242));
    rst_n = 1'b0; port_i = 8'h00; line_tick_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(cmd_valid_o == 1'b0 && cmd_x_o == 0 && cmd_y_o == 0 && cmd_op_o == 0,
        "R1 in reset", {cmd_valid_o, cmd_op_o}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(cmd_valid_o == 1'b0 && cmd_x_o == 0 && cmd_y_o == 0 && cmd_op_o == 0,
        "R1 after reset", {cmd_valid_o, cmd_op_o}, 0);

    // R12: port idle at 0x00 must not count as an opcode byte
    p0 = pulses;
    tick_once();
    send(mk(3'd1, 5'd3)); send(mk(3'd2, 5'd4)); send(mk(3'd3, 5'd5)); send(mk(3'd4, 5'd6));
    chk(pulses == p0, "R12 zero reference", pulses - p0, 0);

    // R2: Y-high placed on port without tick produces nothing until ticked
    send(mk(3'd0, 5'd1)); send(mk(3'd1, 5'd31)); send(mk(3'd2, 5'd31)); send(mk(3'd3, 5'd0));
    p0 = pulses;
    @(negedge clk) port_i = mk(3'd4, 5'd0);
    repeat (12) @(negedge clk);
    chk(pulses == p0, "R2 no tick", pulses - p0, 0);
    // R6 exact timing: valid two cycles after the tick cycle
    @(negedge clk) line_tick_i = 1'b1;
    @(negedge clk) line_tick_i = 1'b0;
    chk(cmd_valid_o == 1'b0, "R6 cycle1", cmd_valid_o, 0);
    @(negedge clk);
    chk(cmd_valid_o == 1'b1, "R6 cycle2", cmd_valid_o, 1);
    @(negedge clk);
    chk(cmd_valid_o == 1'b0, "R6 cycle3", cmd_valid_o, 0);
    expect_cmd("R4 R5 R11 corner", p0, 5'd1, 10'h3FF, 10'h000);

    // R3: repeated ticks over the same port value
    p0 = pulses;
    repeat (5) tick_once();
    chk(pulses == p0, "R3 held byte", pulses - p0, 0);

    // R10 and R9: Y-high after emission without new set
    send(mk(3'd4, 5'd17));
    chk(pulses == p0, "R10 no re-emit", pulses - p0, 0);
    chk(cmd_y_o == 10'h000 && cmd_x_o == 10'h3FF, "R9 hold", cmd_y_o, 0);

    // R7: opcode byte mid-sequence restarts
    p0 = pulses;
    send(mk(3'd0, 5'd2)); send(mk(3'd1, 5'd7)); send(mk(3'd2, 5'd8)); send(mk(3'd3, 5'd9));
    send(mk(3'd0, 5'd3)); send(mk(3'd4, 5'd10));
    chk(pulses == p0, "R7 restart blocks", pulses - p0, 0);
    send(mk(3'd2, 5'd1)); send(mk(3'd3, 5'd2)); send(mk(3'd1, 5'd0)); send(mk(3'd4, 5'd31));
    expect_cmd("R7 after restart", p0, 5'd3, {5'd1, 5'd0}, {5'd31, 5'd2});

    // R8: reserved tags between fields
    p0 = pulses;
    send_cmd(5'd2, 10'h2A5, 10'h15A, 0, 1'b1);
    expect_cmd("R8 reserved ignored", p0, 5'd2, 10'h2A5, 10'h15A);

    // Random sequences
    for (int i = 0; i < 40; i++) begin
      logic [4:0] op;
      logic [9:0] x, y;
      op = 5'(1 + ($urandom % 3));
      x  = 10'($urandom);
      y  = 10'($urandom);
      p0 = pulses;
      send_cmd(op, x, y, int'($urandom % 3), 1'($urandom));
      expect_cmd("R5 R6 random", p0, op, x, y);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule